// File: doc/BRIEF.md
# Command-List Register Dump Engine

This block is a small bus master that gathers register contents on behalf of a host. The host loads a 64-bit script location into two 32-bit registers and writes a start bit. The engine then walks a list of commands in memory. Each command is a pair of 64-bit words. A command either writes one value to an internal register or reads an internal register port a given number of times and stores each 32-bit result to memory.

A typical script first writes a bank-select register and then streams a debug aperture port into a buffer. Registers that the host cannot reach directly are collected this way in one pass. A pair of all-zero words ends the script. The engine then raises a done flag that the host polls.

The engine drives two request/acknowledge masters. One is a memory port used for 64-bit command fetches and 32-bit result stores. The other is a register-bus port toward the internal registers. Only one request is outstanding at any time.

Top module: `regdump_engine`

## Requirements
- R1: Host register 1 holds the low 32 bits of the script base and host register 2 holds the high 32 bits. After a start, command words are fetched from the base and then from each following 8-byte address, with the full 64-bit address on `mem_addr`.
- R2: A host write to register 0 with bit 0 set starts the engine when it is idle. While running, bit 1 of register 0 reads 1.
- R3: When the terminating pair is executed, bit 2 of register 0 becomes 1 and bit 1 returns to 0. Bit 2 stays set until the next accepted start.
- R4: A start written while the engine is running has no effect on the run in progress. An accepted start clears bit 2.
- R5: In the second word of a pair, bits 63:44 give the target register number, bit 21 is the write flag and bits 20:0 give the count.
- R6: When the write flag is set, exactly one register-bus write is issued. It carries the low 32 bits of the first word to the target register. The count field is ignored.
- R7: When the write flag is clear, the target register is read count times at the same address. Result i is stored as a 32-bit word at the first word's address plus 4*i, in read order. The low two address bits are treated as zero.
- R8: A read command with count 0 makes no register access and no store. The engine moves on to the next pair.
- R9: Only a pair in which both words are zero ends the script. A pair with a nonzero first word and a zero second word is executed as an ordinary command.
- R10: Each request, memory or register bus, is held with a stable address until its acknowledge. The two requests are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register select: 0 control, 1 base low, 2 base high |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected host register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a 32-bit store |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 64 | Fetched 64-bit word, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge |
| rb_req | output | 1 | Register-bus request |
| rb_we | output | 1 | Register-bus request is a write |
| rb_addr | output | 20 | Target register number |
| rb_wdata | output | 32 | Register write data |
| rb_rdata | input | 32 | Register read data, valid with acknowledge |
| rb_ack | input | 1 | Register-bus acknowledge |

## Verification
A sequencer stuck in a wrong state or holding a wrong pointer shows up at the ports within a few transfers. It can appear as a fetch from the wrong address, a second start that refetches the script, or a store landing one slot off. A mis-decoded pair shows up as an extra register write or a missing one, or as stored words that disagree with the bank-selected aperture sequence. The done flag is checked against the exact terminator, so a run that stops early or never stops is seen as soon as the host polls.

// File: rtl/regdump_pkg.sv
package regdump_pkg;
  localparam int unsigned CMD_W      = 64;
  localparam int unsigned ADDR_W     = 64;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned REG_LSB    = 44;
  localparam int unsigned RB_AW      = CMD_W - REG_LSB;
  localparam int unsigned WR_BIT     = 21;
  localparam int unsigned CNT_W      = WR_BIT;
  localparam int unsigned FETCH_STEP = CMD_W / 8;
  localparam int unsigned STORE_STEP = DATA_W / 8;

  localparam logic [1:0] HOST_CTRL    = 2'd0;
  localparam logic [1:0] HOST_BASE_LO = 2'd1;
  localparam logic [1:0] HOST_BASE_HI = 2'd2;
  localparam int unsigned CTRL_START = 0;
  localparam int unsigned CTRL_BUSY  = 1;
  localparam int unsigned CTRL_DONE  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_LO, ST_FETCH_HI, ST_EXEC, ST_REG_WR, ST_REG_RD, ST_MEM_ST
  } seq_state_t;

  function automatic logic is_terminator(input logic [CMD_W-1:0] w0, input logic [CMD_W-1:0] w1);
    return (w0 == '0) && (w1 == '0);
  endfunction

  function automatic logic cmd_is_write(input logic [CMD_W-1:0] w1);
    return w1[WR_BIT];
  endfunction

  function automatic logic [CNT_W-1:0] cmd_count(input logic [CMD_W-1:0] w1);
    return w1[CNT_W-1:0];
  endfunction

  function automatic logic [RB_AW-1:0] cmd_reg(input logic [CMD_W-1:0] w1);
    return w1[CMD_W-1:REG_LSB];
  endfunction

  function automatic logic [ADDR_W-1:0] next_fetch(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(FETCH_STEP);
  endfunction

  function automatic logic [ADDR_W-1:0] next_store(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(STORE_STEP);
  endfunction

  function automatic logic [ADDR_W-1:0] align_word(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/regdump_host_regs.sv
module regdump_host_regs
  import regdump_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy,
  input  logic              seq_done,
  output logic              start_pulse,
  output logic              done_flag,
  output logic [ADDR_W-1:0] base_addr
);
  logic [DATA_W-1:0] base_lo_q, base_hi_q;

  assign start_pulse = wr_en && (addr == HOST_CTRL) && wdata[CTRL_START] && !busy;
  assign base_addr   = {base_hi_q, base_lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      done_flag <= 1'b0;
    end else begin
      if (wr_en && addr == HOST_BASE_LO) base_lo_q <= wdata;
      if (wr_en && addr == HOST_BASE_HI) base_hi_q <= wdata;
      if (start_pulse)   done_flag <= 1'b0;
      else if (seq_done) done_flag <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      HOST_CTRL: begin
        rdata[CTRL_BUSY] = busy;
        rdata[CTRL_DONE] = done_flag;
      end
      HOST_BASE_LO: rdata = base_lo_q;
      HOST_BASE_HI: rdata = base_hi_q;
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/regdump_sequencer.sv
module regdump_sequencer
  import regdump_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              busy,
  output logic              seq_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [CMD_W-1:0]  mem_rdata,
  input  logic              mem_ack,
  output logic              rb_req,
  output logic              rb_we,
  output logic [RB_AW-1:0]  rb_addr,
  output logic [DATA_W-1:0] rb_wdata,
  input  logic [DATA_W-1:0] rb_rdata,
  input  logic              rb_ack
);
  seq_state_t        state;
  logic [ADDR_W-1:0] ptr, dst;
  logic [CMD_W-1:0]  w0, w1;
  logic [CNT_W-1:0]  remain;
  logic [DATA_W-1:0] rdq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ptr    <= '0;
      dst    <= '0;
      w0     <= '0;
      w1     <= '0;
      remain <= '0;
      rdq    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          ptr   <= base_addr;
          state <= ST_FETCH_LO;
        end
        ST_FETCH_LO: if (mem_ack) begin
          w0    <= mem_rdata;
          ptr   <= next_fetch(ptr);
          state <= ST_FETCH_HI;
        end
        ST_FETCH_HI: if (mem_ack) begin
          w1    <= mem_rdata;
          ptr   <= next_fetch(ptr);
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (is_terminator(w0, w1))      state <= ST_IDLE;
          else if (cmd_is_write(w1))      state <= ST_REG_WR;
          else if (cmd_count(w1) == '0)   state <= ST_FETCH_LO;
          else begin
            dst    <= align_word(w0);
            remain <= cmd_count(w1);
            state  <= ST_REG_RD;
          end
        end
        ST_REG_WR: if (rb_ack) state <= ST_FETCH_LO;
        ST_REG_RD: if (rb_ack) begin
          rdq   <= rb_rdata;
          state <= ST_MEM_ST;
        end
        ST_MEM_ST: if (mem_ack) begin
          dst    <= next_store(dst);
          remain <= remain - 1'b1;
          state  <= (remain == CNT_W'(1)) ? ST_FETCH_LO : ST_REG_RD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != ST_IDLE);
    seq_done  = (state == ST_EXEC) && is_terminator(w0, w1);
    mem_req   = (state == ST_FETCH_LO) || (state == ST_FETCH_HI) || (state == ST_MEM_ST);
    mem_we    = (state == ST_MEM_ST);
    mem_addr  = (state == ST_MEM_ST) ? dst : ptr;
    mem_wdata = rdq;
    rb_req    = (state == ST_REG_WR) || (state == ST_REG_RD);
    rb_we     = (state == ST_REG_WR);
    rb_addr   = cmd_reg(w1);
    rb_wdata  = w0[DATA_W-1:0];
  end
endmodule

// File: rtl/regdump_engine.sv
module regdump_engine
  import regdump_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [CMD_W-1:0]  mem_rdata,
  input  logic              mem_ack,
  output logic              rb_req,
  output logic              rb_we,
  output logic [RB_AW-1:0]  rb_addr,
  output logic [DATA_W-1:0] rb_wdata,
  input  logic [DATA_W-1:0] rb_rdata,
  input  logic              rb_ack
);
  logic              start_pulse, seq_done, busy, done_flag;
  logic [ADDR_W-1:0] base_addr;

  regdump_host_regs u_host (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .addr(host_addr),
    .wdata(host_wdata), .rdata(host_rdata), .busy(busy), .seq_done(seq_done),
    .start_pulse(start_pulse), .done_flag(done_flag), .base_addr(base_addr)
  );

  regdump_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .base_addr(base_addr),
    .busy(busy), .seq_done(seq_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .rb_req(rb_req), .rb_we(rb_we), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
    .rb_rdata(rb_rdata), .rb_ack(rb_ack)
  );
endmodule

// File: rtl/regdump_engine_chk.sv
module regdump_engine_chk
  import regdump_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rb_req,
  input logic              rb_ack,
  input logic [RB_AW-1:0]  rb_addr,
  input logic              start_pulse,
  input logic              seq_done,
  input logic              busy,
  input logic              done_flag
);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  // R10
  rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_req && !rb_ack |=> rb_req && $stable(rb_addr));
  // R10
  one_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && rb_req));
  // R3
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> done_flag && !busy);
  // R4
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !done_flag && busy);
  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_pulse));
  // R7
  store_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr[1:0] == 2'b00);
endmodule

bind regdump_engine regdump_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .rb_req(rb_req), .rb_ack(rb_ack), .rb_addr(rb_addr),
  .start_pulse(start_pulse), .seq_done(seq_done), .busy(busy), .done_flag(done_flag)
);

// File: tb/regdump_engine_bench.sv
module regdump_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        rb_req, rb_we;
  logic [19:0] rb_addr;
  logic [31:0] rb_wdata;
  logic [31:0] rb_rdata = '0;
  logic        rb_ack = 1'b0;

  int checks = 0, errors = 0;
  int fetch_cnt = 0, store_cnt = 0, rb_wr_cnt = 0, rb_rd_cnt = 0, hi_bad = 0;
  logic [31:0] exp_hi = '0;
  logic [19:0] last_wr_addr;
  logic [31:0] last_wr_data;
  logic [63:0] mem [0:511];
  logic [31:0] bank = '0;
  logic [15:0] ap_idx = '0;
  int wp = 0;

  localparam logic [19:0] SEL_REG = 20'h00B10;
  localparam logic [19:0] AP_REG  = 20'h00B20;

  always #10 clk = ~clk;

  regdump_engine u_regdump_engine (.*);

  function automatic logic [31:0] ap_val(input logic [31:0] b, input int i);
    return {b[7:0], 8'h5A, 16'(i)};
  endfunction
  function automatic logic [63:0] mk_cmd(input logic [19:0] r, input logic wr, input logic [20:0] cnt);
    return {r, 22'b0, wr, cnt};
  endfunction
  function automatic logic [31:0] rd32(input int addr);
    logic [63:0] w = mem[addr[11:3]];
    return addr[2] ? w[63:32] : w[31:0];
  endfunction

  // memory and register bus models, acting at the falling edge
  always @(negedge clk) begin
    if (!rst_n) mem_ack = 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        store_cnt++;
        if (mem_addr[2]) mem[mem_addr[11:3]][63:32] = mem_wdata;
        else             mem[mem_addr[11:3]][31:0]  = mem_wdata;
      end else begin
        fetch_cnt++;
        if (mem_addr[63:32] != exp_hi) hi_bad++;
        mem_rdata = mem[mem_addr[11:3]];
      end
    end else mem_ack = 1'b0;

    if (!rst_n) rb_ack = 1'b0;
    else if (rb_req && !rb_ack) begin
      rb_ack = 1'b1;
      if (rb_we) begin
        rb_wr_cnt++;
        last_wr_addr = rb_addr;
        last_wr_data = rb_wdata;
        if (rb_addr == SEL_REG) begin bank = rb_wdata; ap_idx = '0; end
      end else begin
        rb_rd_cnt++;
        if (rb_addr == AP_REG) begin rb_rdata = ap_val(bank, int'(ap_idx)); ap_idx++; end
        else rb_rdata = {12'hBAD, rb_addr};
      end
    end else rb_ack = 1'b0;
  end

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr_en = 1'b1;
    @(negedge clk);
    host_wr_en = 1'b0; host_addr = 2'd0;
  endtask

  task automatic new_script();
    for (int i = 0; i < 512; i++) mem[i] = 64'h0BAD_0BAD_0BAD_0BAD;
    wp = 0;
    fetch_cnt = 0; store_cnt = 0; rb_wr_cnt = 0; rb_rd_cnt = 0; hi_bad = 0;
  endtask

  task automatic emit(input logic [63:0] w0, input logic [63:0] w1);
    mem[wp] = w0; mem[wp+1] = w1; wp += 2;
  endtask

  task automatic run_to_done(input logic [31:0] lo, input logic [31:0] hi);
    exp_hi = hi;
    host_write(2'd1, lo);
    host_write(2'd2, hi);
    host_write(2'd0, 32'h1);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (host_rdata[2]) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(host_rdata == 32'h0, "R3 reset control", 64'(host_rdata), 64'h0);
    check(!mem_req && !rb_req, "R10 reset idle", {62'b0, mem_req, rb_req}, 64'h0);
  endtask

  task automatic t_basic();
    new_script();
    emit(64'd3, mk_cmd(SEL_REG, 1'b1, 21'd1));
    emit(64'h400, mk_cmd(AP_REG, 1'b0, 21'd5));
    emit(64'd7, mk_cmd(SEL_REG, 1'b1, 21'd1));
    emit(64'h414, mk_cmd(AP_REG, 1'b0, 21'd3));
    emit(64'd0, 64'd0);
    run_to_done(32'h0, 32'h0);
    check(host_rdata[2:1] == 2'b10, "R3 done set busy clear", 64'(host_rdata), 64'h4);
    for (int i = 0; i < 5; i++)
      check(rd32(32'h400 + 4*i) == ap_val(3, i), "R7 bank 3 stream", 64'(rd32(32'h400 + 4*i)), 64'(ap_val(3, i)));
    for (int i = 0; i < 3; i++)
      check(rd32(32'h414 + 4*i) == ap_val(7, i), "R7 bank 7 stream", 64'(rd32(32'h414 + 4*i)), 64'(ap_val(7, i)));
    check(rd32(32'h420) == 32'h0BAD_0BAD, "R7 no store past count", 64'(rd32(32'h420)), 64'h0BAD0BAD);
    check(last_wr_addr == SEL_REG && last_wr_data == 32'd7, "R5 register number", {last_wr_addr, last_wr_data}, {SEL_REG, 32'd7});
    check(fetch_cnt == 10 && hi_bad == 0, "R1 fetch sequence", 64'(fetch_cnt), 64'd10);
  endtask

  task automatic t_write();
    new_script();
    emit(64'hFFFF_FFFF_CAFE_F00D, mk_cmd(20'h00123, 1'b1, 21'd7));
    emit(64'd0, 64'd0);
    run_to_done(32'h0, 32'h0);
    check(rb_wr_cnt == 1 && rb_rd_cnt == 0, "R6 single write", 64'(rb_wr_cnt), 64'd1);
    check(last_wr_addr == 20'h00123 && last_wr_data == 32'hCAFE_F00D, "R6 write target and data",
          {last_wr_addr, last_wr_data}, {20'h00123, 32'hCAFE_F00D});
    check(store_cnt == 0, "R6 no store", 64'(store_cnt), 64'd0);
  endtask

  task automatic t_zero_count();
    new_script();
    emit(64'h600, mk_cmd(AP_REG, 1'b0, 21'd0));
    emit(64'h608, 64'd0);
    emit(64'd5, mk_cmd(SEL_REG, 1'b1, 21'd1));
    emit(64'd0, 64'd0);
    run_to_done(32'h0, 32'h0);
    check(rb_rd_cnt == 0 && store_cnt == 0, "R8 zero count no transfer", 64'(rb_rd_cnt + store_cnt), 64'd0);
    check(rd32(32'h600) == 32'h0BAD_0BAD, "R8 buffer untouched", 64'(rd32(32'h600)), 64'h0BAD0BAD);
    check(rb_wr_cnt == 1 && fetch_cnt == 8, "R9 half-zero pair not terminator", 64'(fetch_cnt), 64'd8);
  endtask

  task automatic t_terminator_only();
    new_script();
    emit(64'd0, 64'd0);
    run_to_done(32'h0, 32'h0);
    check(host_rdata[2] && fetch_cnt == 2, "R9 immediate terminator", 64'(fetch_cnt), 64'd2);
    check(rb_wr_cnt + rb_rd_cnt == 0, "R9 no register access", 64'(rb_wr_cnt + rb_rd_cnt), 64'd0);
  endtask

  task automatic t_busy_start();
    new_script();
    emit(64'd2, mk_cmd(SEL_REG, 1'b1, 21'd1));
    emit(64'h700, mk_cmd(AP_REG, 1'b0, 21'd4));
    emit(64'd0, 64'd0);
    @(negedge clk);
    check(host_rdata[2], "R3 done held from previous run", 64'(host_rdata), 64'h4);
    exp_hi = 32'h0;
    host_write(2'd1, 32'h0);
    host_write(2'd0, 32'h1);
    check(host_rdata[2:1] == 2'b01, "R4 start clears done", 64'(host_rdata), 64'h2);
    repeat (6) @(negedge clk);
    host_write(2'd0, 32'h1);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (host_rdata[2]) break;
    end
    check(fetch_cnt == 6, "R4 busy start ignored", 64'(fetch_cnt), 64'd6);
    check(rd32(32'h70C) == ap_val(2, 3), "R4 run intact", 64'(rd32(32'h70C)), 64'(ap_val(2, 3)));
    repeat (4) @(negedge clk);
    check(!mem_req && host_rdata[2:1] == 2'b10, "R2 idle after run", 64'(host_rdata), 64'h4);
  endtask

  task automatic t_high_base();
    new_script();
    wp = 32;
    emit(64'd9, mk_cmd(SEL_REG, 1'b1, 21'd1));
    emit(64'h0000_0000_0000_0802, mk_cmd(AP_REG, 1'b0, 21'd2));
    emit(64'd0, 64'd0);
    run_to_done(32'h100, 32'h1);
    check(hi_bad == 0 && fetch_cnt == 6, "R1 high base half", 64'(hi_bad), 64'd0);
    check(rd32(32'h800) == ap_val(9, 0) && rd32(32'h804) == ap_val(9, 1), "R7 low address bits ignored",
          64'(rd32(32'h800)), 64'(ap_val(9, 0)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_write();
    t_zero_count();
    t_terminator_only();
    t_busy_start();
    t_high_base();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule